// File: doc/BRIEF.md
# Two-Wire EEPROM Write Front End

This block sits between a two-wire serial bus and the page buffer of a serial EEPROM. It oversamples SCL and SDA with the system clock and recognises start and stop conditions. It takes in the first byte after a start and compares it with a fixed device code and a fixed slave number. On a match with the write direction bit, it acknowledges that byte. It then takes a two-byte word address and any number of data bytes, and acknowledges each of them by pulling SDA low during the ninth clock.

Each data byte appears as a one-cycle strobe that carries the current 13-bit word address and the byte. After each byte the low five address bits step forward and wrap inside the 32-byte page. When a stop follows at least one data byte, a one-cycle commit pulse tells the page buffer to start its internal write. While the buffer reports busy, a start is ignored and nothing is acknowledged.

Top module: `eeprom_wr_slave`

## Requirements
- R1: After reset, `sda_oe`, `wr_stb` and `commit` are low, and the block waits for a start condition.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Data bits are taken on SCL rising edges, most significant bit first.
- R3: The first byte after a start is acknowledged only when it equals 8'hA0: device code 1010 in bits 7:4, slave number 000 in bits 3:1, and 0 (write) in bit 0. Any other value, including the read bit set, gets no acknowledge, and the block ignores the bus until the next start.
- R4: `sda_oe` (1 = pull SDA low) rises only while SCL is low, in the low phase after the eighth bit of an accepted byte. It stays high through the ninth SCL high phase and is released while SCL is low after the ninth clock. It is low while any data bit is transferred.
- R5: The two bytes after an accepted device byte are both acknowledged and form the word address {first[4:0], second[7:0]}. Bits 7:5 of the first byte are ignored.
- R6: Every following byte is acknowledged and produces a one-cycle `wr_stb` with `wr_data` equal to the byte and `wr_addr` equal to the current word address.
- R7: After each data byte, bits 4:0 of the word address are incremented modulo 32 and bits 12:5 are unchanged.
- R8: A stop after at least one data byte produces exactly one one-cycle `commit` pulse. A stop before any data byte produces no `commit` and no `wr_stb`.
- R9: A start in the middle of a transfer abandons the byte in progress and any pending data. Reception begins again with the device byte, and a later stop with no new data produces no `commit`.
- R10: A start seen while `busy` is high is ignored. No acknowledge, strobe or commit follows until a start arrives with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| busy | input | 1 | Internal rewrite in progress |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| wr_stb | output | 1 | One-cycle strobe per received data byte |
| wr_addr | output | 13 | Word address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| commit | output | 1 | One-cycle pulse on a stop that ends a write with data |

## Verification
The bus lines pass through two synchroniser stages and one edge-detect stage, so every result lands on the third clock edge after the bus event that causes it. `wr_stb` follows the eighth SCL rise of a data byte, `sda_oe` rises after the following SCL fall and drops after the ninth fall, and `commit` follows the SDA rise of a stop. The bench holds every SCL phase for five system clocks and drives and samples on falling clock edges. It reads the acknowledge in the middle of the ninth SCL high phase, and a monitor logs strobes and commits. Results are compared only after the transaction ends, when every three-cycle latency has passed.

// File: rtl/eeprom_wr_slave.sv
module eeprom_wr_slave #(
  parameter logic [3:0] DEV_CODE = 4'b1010,
  parameter logic [2:0] SLAVE_ID = 3'b000,
  parameter int         AW       = 13,
  parameter int         PW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          busy,
  output logic          sda_oe,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          commit
);
  localparam int HI = AW - 8;

  typedef enum logic [2:0] {IDLE, DEV, AHI, ALO, DATA} st_t;

  st_t           state;
  logic [2:0]    scl_q, sda_q;
  logic [6:0]    shreg;
  logic [3:0]    cnt;
  logic [AW-1:0] addr;
  logic          ack_pend, got;

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire start_c  = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_c   = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire [7:0] byte_nx = {shreg, sda_q[1]};
  wire match = (byte_nx == {DEV_CODE, SLAVE_ID, 1'b0}) && !busy;
  wire [AW-1:0] addr_nx = {addr[AW-1:PW], addr[PW-1:0] + 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= IDLE;
      shreg    <= '0;
      cnt      <= '0;
      addr     <= '0;
      ack_pend <= 1'b0;
      got      <= 1'b0;
      sda_oe   <= 1'b0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      commit   <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      commit <= 1'b0;
      if (start_c) begin
        state    <= busy ? IDLE : DEV;
        cnt      <= '0;
        sda_oe   <= 1'b0;
        ack_pend <= 1'b0;
        got      <= 1'b0;
      end else if (stop_c) begin
        commit   <= got;
        got      <= 1'b0;
        state    <= IDLE;
        sda_oe   <= 1'b0;
        ack_pend <= 1'b0;
      end else if (state != IDLE) begin
        if (scl_rise) begin
          if (cnt == 4'd8) begin
            cnt <= '0;
          end else begin
            shreg <= byte_nx[6:0];
            cnt   <= cnt + 1'b1;
            if (cnt == 4'd7) begin
              case (state)
                DEV: begin
                  if (match) begin
                    ack_pend <= 1'b1;
                    state    <= AHI;
                  end else begin
                    state <= IDLE;
                  end
                end
                AHI: begin
                  addr[AW-1:8] <= byte_nx[HI-1:0];
                  ack_pend     <= 1'b1;
                  state        <= ALO;
                end
                ALO: begin
                  addr[7:0] <= byte_nx;
                  ack_pend  <= 1'b1;
                  state     <= DATA;
                end
                default: begin
                  wr_stb   <= 1'b1;
                  wr_data  <= byte_nx;
                  wr_addr  <= addr;
                  addr     <= addr_nx;
                  got      <= 1'b1;
                  ack_pend <= 1'b1;
                end
              endcase
            end
          end
        end else if (scl_fall) begin
          if (ack_pend) begin
            sda_oe   <= 1'b1;
            ack_pend <= 1'b0;
          end else if (cnt == 4'd0) begin
            sda_oe <= 1'b0;
          end
        end
      end
    end
  end

  p_ack_rise_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_q[1]));

  p_ack_fall_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && !$past(start_c) && !$past(stop_c)) |-> !$past(scl_q[1]));

  p_oe_active_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> state != IDLE);

  p_stb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  p_commit_needs_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(got) && $past(stop_c)));

  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_c && busy) |-> (state == IDLE && !sda_oe));
endmodule

// File: tb/eeprom_wr_slave_bench.sv
module eeprom_wr_slave_bench;
  localparam int Q = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        busy = 1'b0;
  logic        sda_oe, wr_stb, commit;
  logic [12:0] wr_addr;
  logic [7:0]  wr_data;

  int compared = 0;
  int mismatched = 0;
  int n_stb = 0;
  int n_com = 0;
  logic [12:0] la [64];
  logic [7:0]  ld [64];

  always #10 clk = ~clk;

  eeprom_wr_slave u_eeprom_wr_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(m_sda & ~sda_oe),
    .busy(busy), .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit));

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        if (n_stb < 64) begin
          la[n_stb] = wr_addr;
          ld[n_stb] = wr_data;
        end
        n_stb++;
      end
      if (commit) n_com++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic start_t();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic stop_t();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq(); wq();
  endtask

  task automatic bit_t(input bit b, output bit oe_seen);
    m_sda = b; wq();
    m_scl = 1'b1; wq();
    oe_seen = sda_oe;
    wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack, output bit oe_any);
    bit s;
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bit_t(b[i], s);
      oe_any |= s;
    end
    bit_t(1'b1, ack);
  endtask

  task automatic write_txn(input logic [7:0] hi, input logic [7:0] lo,
                           input int nd, input logic [7:0] seed);
    bit ack, oe;
    int s0, c0;
    logic [12:0] base, ea;
    logic [7:0] ed;
    s0 = n_stb; c0 = n_com;
    base = {hi[4:0], lo};
    start_t();
    send_byte(8'hA0, ack, oe);
    chk(ack, "R3", "device ack", ack, 1);
    send_byte(hi, ack, oe);
    chk(ack && !oe, "R5", "addr hi ack", ack, 1);
    send_byte(lo, ack, oe);
    chk(ack && !oe, "R5", "addr lo ack", ack, 1);
    for (int i = 0; i < nd; i++) begin
      send_byte(seed ^ 8'(i * 37), ack, oe);
      chk(ack, "R6", "data ack", ack, 1);
      chk(!oe, "R4", "oe during data bits", oe, 0);
    end
    stop_t();
    chk(n_stb - s0 == nd, "R6", "strobe count", n_stb - s0, nd);
    for (int i = 0; i < nd && s0 + i < 64; i++) begin
      ea = {base[12:5], 5'(base[4:0] + i)};
      ed = seed ^ 8'(i * 37);
      chk(la[s0+i] == ea, "R7", "strobe address", la[s0+i], ea);
      chk(ld[s0+i] == ed, "R2", "strobe data", ld[s0+i], ed);
    end
    chk(n_com - c0 == (nd > 0 ? 1 : 0), "R8", "commit count", n_com - c0, nd > 0 ? 1 : 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    bit ack, oe, s;
    int s0, c0;
    repeat (4) @(negedge clk);
    chk(!sda_oe && !wr_stb && !commit, "R1", "reset outputs",
        {sda_oe, wr_stb, commit}, 0);
    rst_n = 1'b1;
    wq();
    chk(!sda_oe && n_stb == 0 && n_com == 0, "R1", "idle after reset", sda_oe, 0);

    for (int b = 0; b < 256; b++) begin
      start_t();
      send_byte(8'(b), ack, oe);
      chk(ack == (b == 8'hA0), "R3", "device byte ack", ack, b == 8'hA0);
      chk(!oe, "R4", "oe during address bits", oe, 0);
      if (b != 8'hA0) begin
        send_byte(8'h00, ack, oe);
        chk(!ack, "R3", "ignored after mismatch", ack, 0);
      end
      stop_t();
    end
    chk(n_stb == 0 && n_com == 0, "R8", "no write from address-only", n_stb + n_com, 0);

    write_txn(8'hE3, 8'h1E, 4, 8'h5A);
    write_txn(8'h1F, 8'hFF, 40, 8'hC3);
    write_txn(8'h00, 8'h00, 1, 8'h80);
    write_txn(8'h12, 8'h34, 0, 8'h00);

    s0 = n_stb; c0 = n_com;
    start_t();
    send_byte(8'hA0, ack, oe);
    send_byte(8'h00, ack, oe);
    bit_t(1'b1, s); bit_t(1'b0, s); bit_t(1'b1, s);
    start_t();
    send_byte(8'hA0, ack, oe);
    chk(ack, "R9", "device ack after repeated start", ack, 1);
    send_byte(8'h02, ack, oe);
    send_byte(8'h40, ack, oe);
    send_byte(8'h77, ack, oe);
    stop_t();
    chk(n_stb - s0 == 1, "R9", "strobes after restart", n_stb - s0, 1);
    chk(la[s0] == 13'h0240 && ld[s0] == 8'h77, "R9", "restart address/data",
        {la[s0], ld[s0]}, {13'h0240, 8'h77});
    chk(n_com - c0 == 1, "R9", "commit after restart", n_com - c0, 1);

    s0 = n_stb; c0 = n_com;
    start_t();
    send_byte(8'hA0, ack, oe);
    send_byte(8'h00, ack, oe);
    send_byte(8'h05, ack, oe);
    send_byte(8'h11, ack, oe);
    start_t();
    send_byte(8'hA0, ack, oe);
    stop_t();
    chk(n_stb - s0 == 1, "R9", "strobe before restart", n_stb - s0, 1);
    chk(n_com == c0, "R9", "pending data dropped by restart", n_com - c0, 0);

    s0 = n_stb; c0 = n_com;
    busy = 1'b1;
    start_t();
    send_byte(8'hA0, ack, oe);
    chk(!ack, "R10", "no ack while busy", ack, 0);
    send_byte(8'h00, ack, oe);
    send_byte(8'h00, ack, oe);
    send_byte(8'h99, ack, oe);
    chk(!ack, "R10", "data ignored while busy", ack, 0);
    stop_t();
    busy = 1'b0;
    wq();
    chk(n_stb == s0 && n_com == c0, "R10", "no strobe or commit while busy",
        (n_stb - s0) + (n_com - c0), 0);

    write_txn(8'h03, 8'hFD, 5, 8'h0F);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule